// File: doc/BRIEF.md
# Configurable Lookup-Table Logic Cell

This block is one reprogrammable logic cell for a RAM-configured gate array fabric. Two 16-entry truth tables, called F and G, are held in configuration storage together with a two-bit mode field and two output-register selects. A serial load path fills this storage one bit per clock. Reloading the storage replaces the function the cell computes.

The mode field selects one of four uses of the tables. In the dual mode the cell gives two independent 4-input functions. In the wide mode a fifth input chooses between the two tables, so the cell gives any 5-input function. In the carry mode a dedicated generate/propagate path forms a 2-bit adder slice with carry in and carry out, and this path does not read the tables. In the RAM mode the tables become a 16x2 memory with asynchronous reads and clocked writes.

Each of the two outputs can be taken straight from the logic or from a register. The configuration sets this choice separately for each output. All outputs read 0 while a load is in progress.

Top module: `lut_cell`

## Requirements
- R1: The configuration is 36 bits and is shifted in MSB first on each clock with `cfg_en_i` high. Bits [15:0] hold table F (entry n at bit n) and bits [31:16] hold table G. Bits [33:32] hold the mode: 00 dual, 01 wide, 10 carry, 11 RAM. Bit 34 registers X and bit 35 registers Y. A new load fully replaces the previous function.
- R2: While `cfg_en_i` is high, `x_o`, `y_o` and `carry_o` are 0.
- R3: In dual mode, X = F[`in_f_i`] and Y = G[`in_g_i`], and `carry_o` is 0.
- R4: In wide mode, X = G[`in_f_i`] when `sel_e_i` = 0 and X = F[`in_f_i`] when `sel_e_i` = 1. Y is 0.
- R5: In carry mode, {`carry_o`, Y, X} = `in_f_i`[1:0] + `in_g_i`[1:0] + `carry_i`.
- R6: In RAM mode, X = F[`in_f_i`] and Y = G[`in_f_i`], read without a clock. With `wr_en_i` high, a rising edge writes `wr_data_i`[0] into F[`in_f_i`] and `wr_data_i`[1] into G[`in_f_i`]. `wr_en_i` has no effect when it is low or when the mode is not RAM.
- R7: When its register select bit is 1, an output shows the value its logic held before the last rising edge. When the bit is 0, the output follows the logic without delay.
- R8: With `srst_i` high at a rising edge, the output registers clear to 0. A low `rst_ni` at once clears the output registers and the configuration, which leaves dual mode, all-zero tables and no output registers.
- R9: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| srst_i | input | 1 | Synchronous clear of the output registers |
| cfg_en_i | input | 1 | Configuration shift enable |
| cfg_bit_i | input | 1 | Serial configuration data, MSB first |
| in_f_i | input | 4 | F table inputs, RAM address, adder operand A in [1:0] |
| in_g_i | input | 4 | G table inputs, adder operand B in [1:0] |
| sel_e_i | input | 1 | Fifth input used in wide mode |
| carry_i | input | 1 | Carry in |
| wr_en_i | input | 1 | RAM write enable |
| wr_data_i | input | 2 | RAM write data: bit 0 to F, bit 1 to G |
| x_o | output | 1 | Output X |
| y_o | output | 1 | Output Y |
| carry_o | output | 1 | Carry out |

## Verification
A wrong bit in the configuration storage appears at X or Y as soon as the inputs address the wrong table entry. The bench therefore walks each mode through several addresses and operand pairs, so that table, mode and bit-order faults all produce a wrong value at the ports. Faults in the output registers and the synchronous clear appear one edge late, so those checks sample in the cycle just before and just after each edge. RAM writes are read back one edge after the write, and a blocked write is read back the same way.

// File: rtl/lut_cell_pkg.sv
package lut_cell_pkg;
  localparam int LUT_IN    = 4;
  localparam int LUT_DEPTH = 1 << LUT_IN;
  localparam int NUM_OUT   = 2;
  localparam int MODE_W    = 2;
  localparam int CFG_W     = NUM_OUT * LUT_DEPTH + MODE_W + NUM_OUT;

  typedef enum logic [MODE_W-1:0] {
    MODE_DUAL  = 2'b00,
    MODE_WIDE  = 2'b01,
    MODE_CARRY = 2'b10,
    MODE_RAM   = 2'b11
  } cell_mode_e;

  // Field order is the serial load order (MSB shifted in first)
  typedef struct packed {
    logic                 reg_y;
    logic                 reg_x;
    cell_mode_e           mode;
    logic [LUT_DEPTH-1:0] g_tab;
    logic [LUT_DEPTH-1:0] f_tab;
  } cell_cfg_t;
endpackage

// File: rtl/lut_cfg_store.sv
module lut_cfg_store
  import lut_cell_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_en_i,
  input  logic              cfg_bit_i,
  input  logic              ram_we_i,
  input  logic [LUT_IN-1:0] ram_addr_i,
  input  logic [NUM_OUT-1:0] ram_data_i,
  output cell_cfg_t         cfg_o
);
  cell_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (cfg_en_i) begin
      cfg_q <= cell_cfg_t'({cfg_q[CFG_W-2:0], cfg_bit_i});
    end else if (ram_we_i) begin
      cfg_q.f_tab[ram_addr_i] <= ram_data_i[0];
      cfg_q.g_tab[ram_addr_i] <= ram_data_i[1];
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/lut_func.sv
module lut_func
  import lut_cell_pkg::*;
(
  input  cell_cfg_t         cfg_i,
  input  logic [LUT_IN-1:0] in_f_i,
  input  logic [LUT_IN-1:0] in_g_i,
  input  logic              sel_e_i,
  input  logic              carry_i,
  output logic              x_o,
  output logic              y_o,
  output logic              carry_o
);
  localparam int SLICE_W = NUM_OUT;

  logic [SLICE_W:0]   c_chain;
  logic [SLICE_W-1:0] sum;

  assign c_chain[0] = carry_i;

  // Dedicated generate/propagate path, independent of the tables
  for (genvar i = 0; i < SLICE_W; i++) begin : g_slice
    logic prop, gen;
    assign prop         = in_f_i[i] ^ in_g_i[i];
    assign gen          = in_f_i[i] & in_g_i[i];
    assign sum[i]       = prop ^ c_chain[i];
    assign c_chain[i+1] = gen | (prop & c_chain[i]);
  end

  always_comb begin
    x_o     = 1'b0;
    y_o     = 1'b0;
    carry_o = 1'b0;
    unique case (cfg_i.mode)
      MODE_DUAL: begin
        x_o = cfg_i.f_tab[in_f_i];
        y_o = cfg_i.g_tab[in_g_i];
      end
      MODE_WIDE: begin
        x_o = sel_e_i ? cfg_i.f_tab[in_f_i] : cfg_i.g_tab[in_f_i];
      end
      MODE_CARRY: begin
        x_o     = sum[0];
        y_o     = sum[1];
        carry_o = c_chain[SLICE_W];
      end
      MODE_RAM: begin
        x_o = cfg_i.f_tab[in_f_i];
        y_o = cfg_i.g_tab[in_f_i];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/lut_out_stage.sv
module lut_out_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic srst_i,
  input  logic hold_i,
  input  logic use_reg_i,
  input  logic d_i,
  output logic q_o
);
  logic q_r;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               q_r <= 1'b0;
    else if (srst_i || hold_i) q_r <= 1'b0;
    else                       q_r <= d_i;
  end

  assign q_o = hold_i ? 1'b0 : (use_reg_i ? q_r : d_i);
endmodule

// File: rtl/lut_cell.sv
module lut_cell
  import lut_cell_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              srst_i,
  input  logic              cfg_en_i,
  input  logic              cfg_bit_i,
  input  logic [LUT_IN-1:0] in_f_i,
  input  logic [LUT_IN-1:0] in_g_i,
  input  logic              sel_e_i,
  input  logic              carry_i,
  input  logic              wr_en_i,
  input  logic [NUM_OUT-1:0] wr_data_i,
  output logic              x_o,
  output logic              y_o,
  output logic              carry_o
);
  cell_cfg_t          cfg_q;
  cell_mode_e         cur_mode;
  logic               ram_we;
  logic               x_c, y_c, co_c;
  logic [NUM_OUT-1:0] comb_out, use_reg, out_q;

  assign cur_mode = cfg_q.mode;
  assign ram_we   = wr_en_i && !cfg_en_i && (cur_mode == MODE_RAM);

  lut_cfg_store u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_en_i   (cfg_en_i),
    .cfg_bit_i  (cfg_bit_i),
    .ram_we_i   (ram_we),
    .ram_addr_i (in_f_i),
    .ram_data_i (wr_data_i),
    .cfg_o      (cfg_q)
  );

  lut_func u_func (
    .cfg_i   (cfg_q),
    .in_f_i  (in_f_i),
    .in_g_i  (in_g_i),
    .sel_e_i (sel_e_i),
    .carry_i (carry_i),
    .x_o     (x_c),
    .y_o     (y_c),
    .carry_o (co_c)
  );

  assign comb_out = {y_c, x_c};
  assign use_reg  = {cfg_q.reg_y, cfg_q.reg_x};

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
    lut_out_stage u_stage (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .srst_i    (srst_i),
      .hold_i    (cfg_en_i),
      .use_reg_i (use_reg[k]),
      .d_i       (comb_out[k]),
      .q_o       (out_q[k])
    );
  end

  assign x_o     = out_q[0];
  assign y_o     = out_q[1];
  assign carry_o = cfg_en_i ? 1'b0 : co_c;
endmodule

// File: rtl/lut_cell_chk.sv
module lut_cell_chk
  import lut_cell_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              srst_i,
  input logic              cfg_en_i,
  input logic [LUT_IN-1:0] in_f_i,
  input logic [LUT_IN-1:0] in_g_i,
  input logic              carry_i,
  input logic              wr_en_i,
  input logic [NUM_OUT-1:0] wr_data_i,
  input logic              x_o,
  input logic              y_o,
  input logic              carry_o,
  input cell_mode_e        mode,
  input logic              reg_x,
  input logic              x_comb
);
  // R2
  cfg_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_en_i |-> (!x_o && !y_o && !carry_o));

  // R4
  wide_y_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_WIDE && !cfg_en_i) |-> !y_o);

  // R5
  carry_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_CARRY && !cfg_en_i) |->
      (carry_o == (({1'b0, in_f_i[1:0]} + {1'b0, in_g_i[1:0]} + {2'b00, carry_i}) >= 3'd4)));

  // R6
  ram_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_RAM && wr_en_i && !cfg_en_i && !reg_x) |=>
      (!$stable(in_f_i) || cfg_en_i || x_o == $past(wr_data_i[0])));

  // R7
  reg_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_x && !cfg_en_i && $past(!cfg_en_i && !srst_i)) |-> (x_o == $past(x_comb)));

  // R8
  sync_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(srst_i) && reg_x && !cfg_en_i) |-> !x_o);
endmodule

bind lut_cell lut_cell_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .srst_i    (srst_i),
  .cfg_en_i  (cfg_en_i),
  .in_f_i    (in_f_i),
  .in_g_i    (in_g_i),
  .carry_i   (carry_i),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .x_o       (x_o),
  .y_o       (y_o),
  .carry_o   (carry_o),
  .mode      (cur_mode),
  .reg_x     (use_reg[0]),
  .x_comb    (x_c)
);

// File: tb/tb_lut_cell.sv
module tb_lut_cell;
  localparam time CLK_P  = 8ns;
  localparam int  CW     = 36;
  localparam int  NVEC   = 12;
  localparam logic [15:0] F_PAR = 16'h6996; // entry n = parity of n
  localparam logic [15:0] G_AND = 16'h8000; // entry n = (n == 15)

  // {mode[1:0], f[3:0], g[3:0], e, cin, x, y, co}
  localparam logic [14:0] VEC [NVEC] = '{
    {2'b00, 4'h7, 4'hF, 1'b0, 1'b0, 3'b110},
    {2'b00, 4'h0, 4'hE, 1'b0, 1'b0, 3'b000},
    {2'b00, 4'h1, 4'hF, 1'b0, 1'b0, 3'b110},
    {2'b01, 4'h3, 4'h0, 1'b0, 1'b0, 3'b000},
    {2'b01, 4'hF, 4'h0, 1'b0, 1'b0, 3'b100},
    {2'b01, 4'hF, 4'h0, 1'b1, 1'b0, 3'b000},
    {2'b01, 4'h8, 4'h0, 1'b1, 1'b0, 3'b100},
    {2'b10, 4'h3, 4'h3, 1'b0, 1'b1, 3'b111},
    {2'b10, 4'h1, 4'h2, 1'b0, 1'b0, 3'b110},
    {2'b10, 4'h2, 4'h2, 1'b0, 1'b0, 3'b001},
    {2'b10, 4'h0, 4'h0, 1'b0, 1'b1, 3'b100},
    {2'b10, 4'h3, 4'h0, 1'b0, 1'b1, 3'b001}
  };

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0, srst = 1'b0, cfg_en = 1'b0, cfg_bit = 1'b0;
  logic [3:0] in_f = '0, in_g = '0;
  logic       sel_e = 1'b0, cin = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_data = '0;
  logic       x, y, co;
  int         n_chk = 0, n_err = 0;
  bit         done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  lut_cell dut (
    .clk_i(clk), .rst_ni(rst_ni), .srst_i(srst), .cfg_en_i(cfg_en), .cfg_bit_i(cfg_bit),
    .in_f_i(in_f), .in_g_i(in_g), .sel_e_i(sel_e), .carry_i(cin),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .x_o(x), .y_o(y), .carry_o(co)
  );

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [CW-1:0] cword(input logic ry, input logic rx, input logic [1:0] m,
                                          input logic [15:0] g, input logic [15:0] f);
    return {ry, rx, m, g, f};
  endfunction

  task automatic load_cfg(input logic [CW-1:0] w);
    for (int i = CW - 1; i >= 0; i--) begin
      @(negedge clk); cfg_en = 1'b1; cfg_bit = w[i];
    end
    @(negedge clk); cfg_en = 1'b0;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [1:0] cur_mode;
    string tag;
    repeat (3) @(negedge clk);
    in_f = 4'h7; in_g = 4'hF;
    #1 check("R9 reset outputs", {x, y, co}, 3'b000);
    rst_ni = 1'b1;
    @(negedge clk); #1 check("R9 after release", {x, y, co}, 3'b000);

    // Vector walk over the combinational modes
    cur_mode = 2'b11;
    for (int v = 0; v < NVEC; v++) begin
      if (VEC[v][14:13] != cur_mode) begin
        cur_mode = VEC[v][14:13];
        load_cfg(cword(1'b0, 1'b0, cur_mode, G_AND, F_PAR));
      end
      @(negedge clk);
      in_f = VEC[v][12:9]; in_g = VEC[v][8:5]; sel_e = VEC[v][4]; cin = VEC[v][3];
      #1;
      case (cur_mode)
        2'b00:   tag = "R3 dual";
        2'b01:   tag = "R4 wide";
        default: tag = "R5 carry";
      endcase
      check(tag, {x, y, co}, VEC[v][2:0]);
    end
    sel_e = 1'b0; cin = 1'b0;

    // R2: outputs quiet mid-load, then reflect the new tables (R1)
    in_f = 4'h3; in_g = 4'hF;
    begin
      logic [CW-1:0] w;
      w = cword(1'b0, 1'b0, 2'b00, 16'hFFFF, 16'hFFFF);
      for (int i = CW - 1; i >= 0; i--) begin
        @(negedge clk); cfg_en = 1'b1; cfg_bit = w[i];
        if (i == 0) begin #1 check("R2 quiet during load", {x, y, co}, 3'b000); end
      end
      @(negedge clk); cfg_en = 1'b0;
      #1 check("R1 all-ones tables loaded", {x, y, co}, 3'b110);
    end
    load_cfg(cword(1'b0, 1'b0, 2'b00, 16'h0000, F_PAR));
    in_f = 4'h1;
    #1 check("R1 reload replaces function", {x, y, co}, 3'b100);
    load_cfg(cword(1'b0, 1'b0, 2'b00, 16'h0000, ~F_PAR));
    #1 check("R1 reload inverted table", {x, y, co}, 3'b000);

    // R7: Y registered, X combinational
    load_cfg(cword(1'b1, 1'b0, 2'b00, G_AND, F_PAR));
    in_f = 4'h1; in_g = 4'hF;
    #1 check("R7 before edge", {x, y, co}, 3'b100);
    @(negedge clk); #1 check("R7 after edge", {x, y, co}, 3'b110);
    in_g = 4'h0;
    #1 check("R7 held until edge", {x, y, co}, 3'b110);
    @(negedge clk); #1 check("R7 registered fall", {x, y, co}, 3'b100);

    // R8: synchronous clear
    in_g = 4'hF;
    @(negedge clk); #1 check("R8 pre clear", {x, y, co}, 3'b110);
    srst = 1'b1;
    @(negedge clk); #1 check("R8 sync clear", {x, y, co}, 3'b100);
    srst = 1'b0;
    @(negedge clk); #1 check("R8 recapture", {x, y, co}, 3'b110);

    // R8: asynchronous reset clears registers and configuration
    #1 rst_ni = 1'b0;
    #1 check("R8 async clear", {x, y, co}, 3'b000);
    @(negedge clk); rst_ni = 1'b1;
    #1 check("R8 config cleared", {x, y, co}, 3'b000);

    // R6: RAM mode
    load_cfg(cword(1'b0, 1'b0, 2'b11, 16'h0000, 16'h0000));
    in_f = 4'h5; wr_data = 2'b01; wr_en = 1'b1;
    #1 check("R6 before write", {x, y, co}, 3'b000);
    @(negedge clk); wr_en = 1'b0;
    #1 check("R6 read after write", {x, y, co}, 3'b100);
    in_f = 4'h6;
    #1 check("R6 other address", {x, y, co}, 3'b000);
    in_f = 4'h5; wr_data = 2'b10;
    @(negedge clk); #1 check("R6 write disabled", {x, y, co}, 3'b100);
    wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    #1 check("R6 overwrite", {x, y, co}, 3'b010);

    // R6: write enable ignored outside RAM mode
    load_cfg(cword(1'b0, 1'b0, 2'b00, 16'h0000, 16'h0000));
    in_f = 4'h3; in_g = 4'h3; wr_data = 2'b11; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    #1 check("R6 no write in dual", {x, y, co}, 3'b000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule